// File: doc/BRIEF.md
# I2C Master SCL Clock Generator

This block produces the SCL clock of an I2C master and tolerates slaves that stretch the clock. It drives the line open-drain style: `scl_pull_o` high means the line is pulled low, low means the line is released and floats high through the bus pull-up. The real line level comes back on `scl_i`, passes a two-flop synchronizer and is looked at once per machine cycle (four system clocks).

A 7-bit counter, reloaded from `reload_i`, times both halves of each SCL period in machine cycles. When a low interval expires the line is released, and the counter stays frozen until the synchronized line is seen high. Only then is it reloaded and the high interval timed, so a slave that holds SCL low can never shorten the following high phase. A sequencing controller requests a start, a byte of clock pulses, a repeated start or a stop. The block reports the end of each low and each high interval with one-cycle strobes, which the controller uses to move SDA.

Top module: `i2c_scl_gen`

## Requirements
- R1: While `rst_ni` is low, `scl_pull_o`, `low_done_o` and `high_done_o` are 0. Reset takes effect at once and aborts any transfer.
- R2: A low interval keeps `scl_pull_o`=1 for exactly 4*Re clocks, with Re = `reload_i` (or 1, see R6) sampled at the load. `low_done_o` pulses for one cycle in the first cycle the line is released. The first low of a command ends 4*Re+1 clocks after the cycle its request is sampled.
- R3: After a release, the counter does not advance while the synchronized line reads low. No high interval ends during that time, and `scl_pull_o` stays 0.
- R4: The high interval is timed from the first machine-cycle sample that finds the synchronized line high. Without stretching, the line is released for exactly 4*Re+4 clocks. With stretching, the line stays high for between 4*Re+2 and 4*Re+5 clocks, and never less than 4*Re.
- R5: At the end of a high interval, `high_done_o` pulses for one cycle. In that same cycle `scl_pull_o` becomes 1, unless a stop is in progress.
- R6: A `reload_i` value of 0 times the same interval as a value of 1.
- R7: `start_i` while idle gives one high interval. `high_done_o` appears 4*Re+5 clocks after the request cycle, and the block then parks with SCL pulled low.
- R8: `byte_i` while parked gives NBITS full clock pulses. Each pulse gives one `low_done_o` and one `high_done_o`, and the block parks low afterwards.
- R9: `rstart_i` while parked gives exactly one full clock pulse and then parks low.
- R10: `stop_i` while parked gives one low interval and one high interval. SCL then stays released and the block is idle.
- R11: Requests that arrive outside the parked states are ignored. In the idle state only `start_i` is honoured. While parked, `stop_i` wins over `rstart_i`, which wins over `byte_i`.
- R12: With `en_i`=0 the block goes idle. From the next cycle SCL is released, no strobe appears and every request is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Block enable |
| reload_i | input | CNT_W | Interval length in machine cycles (0 acts as 1) |
| start_i | input | 1 | Start-condition request (honoured when idle) |
| rstart_i | input | 1 | Repeated-start request (honoured when parked) |
| stop_i | input | 1 | Stop-condition request (honoured when parked) |
| byte_i | input | 1 | Byte clocking request, NBITS pulses (honoured when parked) |
| scl_i | input | 1 | Level sampled from the SCL line |
| scl_pull_o | output | 1 | 1 pulls SCL low, 0 releases it |
| low_done_o | output | 1 | One-cycle strobe: low interval finished |
| high_done_o | output | 1 | One-cycle strobe: high interval finished |

## Verification
Assertions check on every cycle that the counter stays frozen while SCL is released and not yet seen high, and that a high interval is never entered while the synchronized line is low. They also check that each strobe coincides with the matching edge of `scl_pull_o`, and that disabling releases the line on the next cycle. Only the bench scenarios can show the exact interval lengths in clocks, the bounds on the high time after a slave stretches the clock, the pulse counts of each command, the request priorities and the behaviour of reload value 0. The bench shows these by sweeping the reload value over a small pulse count.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,  // line released, no activity
    ST_HOLD = 3'd1,  // parked with line pulled low
    ST_LOW  = 3'd2,  // timing low interval
    ST_REL  = 3'd3,  // released, waiting for line high
    ST_HIGH = 3'd4   // timing high interval
  } scl_state_e;
endpackage

// File: rtl/i2c_scl_sync.sv
module i2c_scl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;  // idle bus reads high
    else         sync_q <= {sync_q[STAGES-2:0], d_i};
  end

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/i2c_scl_baud.sv
module i2c_scl_baud #(
  parameter int CNT_W    = 7,
  parameter int TICK_DIV = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             cnt_run_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             tick_o,
  output logic             ovf_o
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;

  generate
    if (TICK_DIV > 1) begin : g_pre
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
      logic [PRE_W-1:0] pre_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                pre_q <= '0;
        else if (!run_i || load_i)  pre_q <= '0;
        else if (pre_q == PRE_LAST) pre_q <= '0;
        else                        pre_q <= pre_q + PRE_W'(1);
      end
      assign tick_o = run_i && (pre_q == PRE_LAST);
    end else begin : g_nopre
      assign tick_o = run_i;
    end
  endgenerate

  // zero reload behaves as one count
  assign load_val = (reload_i == '0) ? CNT_ONE : reload_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    cnt_q <= CNT_ONE;
    else if (load_i)                                cnt_q <= load_val;
    else if (tick_o && cnt_run_i && cnt_q != CNT_ONE) cnt_q <= cnt_q - CNT_ONE;
  end

  assign ovf_o = tick_o && cnt_run_i && (cnt_q == CNT_ONE);

  assert_cnt_frozen_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !cnt_run_i && !load_i) |=> $stable(cnt_q));

  assert_cnt_nonzero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q != '0);
endmodule

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen
  import i2c_scl_pkg::*;
#(
  parameter int CNT_W       = 7,
  parameter int TICK_DIV    = 4,
  parameter int NBITS       = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             start_i,
  input  logic             rstart_i,
  input  logic             stop_i,
  input  logic             byte_i,
  input  logic             scl_i,
  output logic             scl_pull_o,
  output logic             low_done_o,
  output logic             high_done_o
);
  localparam int LEFT_W = $clog2(NBITS + 1);
  localparam logic [LEFT_W-1:0] LEFT_ONE  = LEFT_W'(1);
  localparam logic [LEFT_W-1:0] LEFT_BYTE = LEFT_W'(NBITS);

  scl_state_e        st_q, st_d;
  logic [LEFT_W-1:0] left_q, left_d;
  logic              stop_q, stop_d;
  logic              pull_q, pull_d;
  logic              lo_q, lo_d, hi_q, hi_d;
  logic              load, run, cnt_run, tick, ovf, scl_s;

  i2c_scl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (scl_i),
    .q_o   (scl_s)
  );

  assign run     = (st_q == ST_LOW) || (st_q == ST_REL) || (st_q == ST_HIGH);
  assign cnt_run = (st_q != ST_REL);

  i2c_scl_baud #(.CNT_W(CNT_W), .TICK_DIV(TICK_DIV)) u_baud (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .cnt_run_i(cnt_run),
    .load_i   (load),
    .reload_i (reload_i),
    .tick_o   (tick),
    .ovf_o    (ovf)
  );

  always_comb begin
    st_d   = st_q;
    left_d = left_q;
    stop_d = stop_q;
    pull_d = pull_q;
    lo_d   = 1'b0;
    hi_d   = 1'b0;
    load   = 1'b0;
    if (!en_i) begin
      st_d   = ST_IDLE;
      left_d = '0;
      stop_d = 1'b0;
      pull_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_d   = ST_REL;
          left_d = LEFT_ONE;
        end
        ST_HOLD: begin
          // priority: stop, repeated start, byte
          if (stop_i) begin
            st_d = ST_LOW; load = 1'b1; stop_d = 1'b1; left_d = LEFT_ONE;
          end else if (rstart_i) begin
            st_d = ST_LOW; load = 1'b1; left_d = LEFT_ONE;
          end else if (byte_i) begin
            st_d = ST_LOW; load = 1'b1; left_d = LEFT_BYTE;
          end
        end
        ST_LOW: if (ovf) begin
          st_d   = ST_REL;
          pull_d = 1'b0;
          lo_d   = 1'b1;
        end
        ST_REL: if (tick && scl_s) begin
          st_d = ST_HIGH;
          load = 1'b1;  // high time starts only once line seen high
        end
        ST_HIGH: if (ovf) begin
          hi_d = 1'b1;
          if (stop_q) begin
            st_d = ST_IDLE; stop_d = 1'b0; left_d = '0;
          end else if (left_q > LEFT_ONE) begin
            st_d = ST_LOW; load = 1'b1; pull_d = 1'b1; left_d = left_q - LEFT_ONE;
          end else begin
            st_d = ST_HOLD; pull_d = 1'b1; left_d = '0;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      left_q <= '0;
      stop_q <= 1'b0;
      pull_q <= 1'b0;
      lo_q   <= 1'b0;
      hi_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      left_q <= left_d;
      stop_q <= stop_d;
      pull_q <= pull_d;
      lo_q   <= lo_d;
      hi_q   <= hi_d;
    end
  end

  assign scl_pull_o  = pull_q;
  assign low_done_o  = lo_q;
  assign high_done_o = hi_q;

  assert_rel_released_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_REL) |-> !scl_pull_o);

  assert_no_high_while_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_REL && !scl_s) |=> (st_q != ST_HIGH));

  assert_low_done_edge_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_done_o |-> (!scl_pull_o && $past(scl_pull_o)));

  assert_high_done_from_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    high_done_o |-> $past(st_q == ST_HIGH));

  assert_strobe_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({low_done_o, high_done_o}));

  assert_disable_release_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!scl_pull_o && !low_done_o && !high_done_o));
endmodule

// File: tb/i2c_scl_gen_bench.sv
`timescale 1ns/100ps
module i2c_scl_gen_bench;
  localparam int NB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       en = 1'b0, start = 1'b0, rstart = 1'b0, stop = 1'b0, byte_r = 1'b0;
  logic [6:0] rel = 7'd1;
  logic       pull, lo_d, hi_d;
  logic       stretch = 1'b0;
  logic       line;
  assign line = !pull && !stretch;

  i2c_scl_gen #(.CNT_W(7), .TICK_DIV(4), .NBITS(NB), .SYNC_STAGES(2)) u_i2c_scl_gen (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .reload_i(rel),
    .start_i(start), .rstart_i(rstart), .stop_i(stop), .byte_i(byte_r),
    .scl_i(line), .scl_pull_o(pull), .low_done_o(lo_d), .high_done_o(hi_d)
  );

  int total = 0, bad = 0;
  int cyc = 0, n_lo = 0, n_hi = 0, t_lo = 0, t_hi = 0;
  int lo_run = 0, hi_run = 0, last_lo = 0, last_hi = 0;
  int st_len = 0, st_cnt = 0, hi_in_stretch = 0;
  bit st_arm = 1'b0;

  // line monitor and slave stretch model
  always @(negedge clk) begin
    cyc++;
    if (lo_d) begin n_lo++; t_lo = cyc; end
    if (hi_d) begin n_hi++; t_hi = cyc; if (stretch) hi_in_stretch++; end
    if (pull) begin
      lo_run++;
      if (hi_run != 0) last_hi = hi_run;
      hi_run = 0;
    end else begin
      if (lo_run != 0) last_lo = lo_run;
      lo_run = 0;
      if (line) hi_run++;
    end
    if (st_arm && pull) begin
      stretch = 1'b1; st_arm = 1'b0; st_cnt = 0;
    end else if (stretch && !pull) begin
      st_cnt++;
      if (st_cnt == st_len) stretch = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic tick_wait();
    @(negedge clk); #1;
  endtask

  task automatic pulse(input bit s, input bit r, input bit p, input bit b, output int c0);
    tick_wait();
    c0 = cyc;
    start = s; rstart = r; stop = p; byte_r = b;
    tick_wait();
    start = 1'b0; rstart = 1'b0; stop = 1'b0; byte_r = 1'b0;
  endtask

  task automatic wait_hi(input int target, input string req);
    int guard = 0;
    while (n_hi < target && guard < 20000) begin tick_wait(); guard++; end
    chk(n_hi >= target, req, n_hi, target);
  endtask

  task automatic wait_lo(input int target, input string req);
    int guard = 0;
    while (n_lo < target && guard < 20000) begin tick_wait(); guard++; end
    chk(n_lo >= target, req, n_lo, target);
  endtask

  task automatic quiet(input bit exp_pull, input string req);
    int l0 = n_lo, h0 = n_hi;
    bit ok = 1'b1;
    for (int i = 0; i < 20; i++) begin
      tick_wait();
      if (pull != exp_pull) ok = 1'b0;
    end
    chk(ok && n_lo == l0 && n_hi == h0, req, int'(pull), int'(exp_pull));
  endtask

  task automatic run_reload(input int r, input bit do_stretch);
    int re = (r == 0) ? 1 : r;
    int c0, l0, h0;
    tick_wait();
    rel = 7'(r);
    // R7 start from idle
    h0 = n_hi;
    pulse(1, 0, 0, 0, c0);
    wait_hi(h0 + 1, "R7 start high_done");
    chk(t_hi == c0 + 5 + 4 * re, (r == 0) ? "R6 zero reload start" : "R7 start timing",
        t_hi - c0, 5 + 4 * re);
    quiet(1'b1, "R7 parked low after start");
    // R8 byte, optionally stretched on first bit
    if (do_stretch) begin st_len = 4 * re + 12; st_arm = 1'b1; hi_in_stretch = 0; tick_wait(); end
    l0 = n_lo; h0 = n_hi;
    pulse(0, 0, 0, 1, c0);
    for (int b = 0; b < NB; b++) begin
      wait_lo(l0 + b + 1, "R8 low_done");
      if (b == 0) chk(t_lo == c0 + 1 + 4 * re, "R2 first low", t_lo - c0, 1 + 4 * re);
      else        chk(last_lo == 4 * re, (r == 0) ? "R6 low length" : "R2 low length", last_lo, 4 * re);
      wait_hi(h0 + b + 1, "R8 high_done");
      if (b == 0 && do_stretch) begin
        chk(last_hi >= 4 * re + 2 && last_hi <= 4 * re + 5, "R4 stretched high", last_hi, 4 * re + 2);
        chk(hi_in_stretch == 0, "R3 no high end during stretch", hi_in_stretch, 0);
      end else begin
        chk(last_hi == 4 * re + 4, "R4 high length", last_hi, 4 * re + 4);
      end
      chk(pull == 1'b1 || b == NB - 1, "R5 pull after high", int'(pull), 1);
      if (b == 0) begin
        int cx;
        pulse(1, 1, 1, 1, cx);  // R11 ignored while busy
      end
    end
    chk(n_lo - l0 == NB && n_hi - h0 == NB, "R8 pulse count", n_hi - h0, NB);
    quiet(1'b1, "R8 parked low after byte / R11");
    // R9 repeated start, outranks byte
    l0 = n_lo; h0 = n_hi;
    pulse(0, 1, 0, 1, c0);
    wait_hi(h0 + 1, "R9 high_done");
    chk(t_lo == c0 + 1 + 4 * re, "R9 low timing", t_lo - c0, 1 + 4 * re);
    chk(t_hi - t_lo == 4 * re + 4, "R9 high timing", t_hi - t_lo, 4 * re + 4);
    quiet(1'b1, "R9 single pulse then parked / R11");
    chk(n_lo - l0 == 1, "R9 one low", n_lo - l0, 1);
    // R10 stop wins over rstart and byte
    h0 = n_hi;
    pulse(0, 1, 1, 1, c0);
    wait_hi(h0 + 1, "R10 high_done");
    chk(t_lo == c0 + 1 + 4 * re, "R10 low timing", t_lo - c0, 1 + 4 * re);
    chk(t_hi - t_lo == 4 * re + 4, "R10 high timing", t_hi - t_lo, 4 * re + 4);
    quiet(1'b0, "R10 released and idle / R11");
    // R11 idle ignores all but start
    pulse(0, 1, 1, 1, c0);
    quiet(1'b0, "R11 idle ignores requests");
  endtask

  initial begin : main
    int c0, h0;
    repeat (3) tick_wait();
    chk(pull == 0 && lo_d == 0 && hi_d == 0, "R1 reset outputs", int'(pull), 0);
    rst_n = 1'b1;
    en = 1'b1;
    for (int r = 0; r < 8; r++) run_reload(r, (r % 2) == 1);
    run_reload(127, 1'b1);
    run_reload(0, 1'b1);
    // R12 disable mid-byte
    rel = 7'd3;
    pulse(1, 0, 0, 0, c0);
    wait_hi(n_hi + 1, "R12 setup start");
    pulse(0, 0, 0, 1, c0);
    wait_lo(n_lo + 1, "R12 setup low");
    repeat (3) tick_wait();
    en = 1'b0;
    tick_wait();
    chk(pull == 0, "R12 released after disable", int'(pull), 0);
    pulse(1, 0, 0, 1, c0);
    quiet(1'b0, "R12 requests ignored while disabled");
    en = 1'b1;
    rel = 7'd2;
    h0 = n_hi;
    pulse(1, 0, 0, 0, c0);
    wait_hi(h0 + 1, "R12 restart");
    chk(t_hi == c0 + 13, "R12 start after re-enable", t_hi - c0, 13);
    // R1 reset mid-transfer
    pulse(0, 0, 0, 1, c0);
    repeat (2) tick_wait();
    rst_n = 1'b0;
    #0.5;
    chk(pull == 0 && lo_d == 0 && hi_d == 0, "R1 async reset aborts", int'(pull), 0);
    tick_wait();
    rst_n = 1'b1;
    quiet(1'b0, "R1 idle after reset");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule